// File: doc/BRIEF.md
# OTP Word Programming Pulse Sequencer

This block burns one 32-bit word into a one-time-programmable memory macro. A requester stages the data word first and then writes a 10-bit word address. When the address write arrives while the controller is in program mode, that write launches the request. The block then raises the macro's program enable and waits a setup time. After that it fires one timed pulse for every bit that is 1 in the word. Between pulses it waits a gap time. After the last pulse it waits a hold time, drops program enable, and waits a recovery time before it reports itself idle.

Every duration is counted in microseconds taken from a shared one-cycle tick. The staging buffer is a single entry. It frees itself as soon as the sequencer has copied the request into its working registers. A second request can therefore wait in the buffer while the first one is still pulsing. A 2-bit array select, captured together with the address, chooses whether the normal array, the redundancy array or both receive the pulses.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, buffer-empty and programming-ready both read 1, and program enable and pulse both read 0.
- R2: The data and address registers accept writes only while buffer-empty is 1. An address write in program mode drops buffer-empty to 0 on the next cycle. Writes made while buffer-empty is 0 are ignored, so a queued request runs with the values it held when it was queued.
- R3: An address write made while program mode is off launches nothing: buffer-empty stays 1, programming-ready stays 1 and program enable never rises.
- R4: Only the bits that are 1 in the data word are pulsed, in ascending bit order. During each pulse the bit-select output carries that bit's index.
- R5: The array select is sampled with the address write. Code 0 selects both arrays, code 1 the normal array only, and code 2 the redundancy array only. The array output is 2'b01 for the normal array and 2'b10 for the redundancy array. With code 0, the full bit sequence runs on the normal array and is then repeated on the redundancy array.
- R6: A launch with array-select code 3 produces no program enable and no pulse. Buffer-empty returns to 1 one cycle after it drops, and programming-ready stays 1.
- R7: Each pulse stays high for exactly PULSE_US microsecond ticks.
- R8: While program enable is high and no pulse is active, the ticks add up to SETUP_US + GAP_US×(pulses−1) + HOLD_US, or to SETUP_US + HOLD_US when there are no pulses.
- R9: After program enable falls, programming-ready stays 0 for exactly RECOV_US ticks and then returns to 1.
- R10: Buffer-empty returns to 1 one cycle after the sequencer takes the request. At that point programming-ready is 0, and the macro address output holds the requested address for every pulse of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond from the shared timebase |
| prog_mode | input | 1 | Controller is in program mode |
| arr_sel_in | input | 2 | Array select, sampled with the address write |
| data_we | input | 1 | Write strobe for the data word |
| data_in | input | 32 | Data word to be programmed |
| addr_we | input | 1 | Write strobe for the address; acts as the launch trigger |
| addr_in | input | 10 | Word address |
| stat_empty | output | 1 | Staging buffer is free |
| stat_ready | output | 1 | Programming logic is idle |
| otp_addr | output | 10 | Word address presented to the macro |
| otp_bit | output | 5 | Index of the bit being pulsed |
| otp_arr | output | 2 | Array being written: bit 0 normal, bit 1 redundancy |
| otp_pgm_en | output | 1 | Program enable to the macro |
| otp_pulse | output | 1 | Programming pulse |

## Verification
The bench shortens the timing parameters to the low end of the allowed ranges: setup 5, pulse 10, gap 1, hold 5 and recovery 5 ticks, with one tick every four clocks. At these values a full 32-bit word, and a word pulsed on both arrays, finish within a few thousand cycles. The exact tick counts for pulse width, setup, gap, hold and recovery can then be compared for every request. Because the timing is short, a second request can be queued while the first is still running. That makes the write-lock window and the ordering of two requests observable at the ports.

// File: rtl/otp_prog_pkg.sv
// Shared types for the OTP programming sequencer.
// Assumes: array-select codes are fixed by the register interface.
package otp_prog_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_SCAN,
        SQ_PULSE,
        SQ_GAP,
        SQ_HOLD,
        SQ_RECOV
    } seq_state_e;

    localparam logic [1:0] ARR_BOTH = 2'd0;
    localparam logic [1:0] ARR_NORM = 2'd1;
    localparam logic [1:0] ARR_RED  = 2'd2;
    localparam logic [1:0] ARR_RSVD = 2'd3;
endpackage

// File: rtl/otp_pbuf.sv
// One-entry staging buffer: the data word, the address and the array select.
// An address write made in program mode marks the entry full. The sequencer
// empties it with 'take'. Assumes 'take' is only raised while the entry is full.
module otp_pbuf #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_mode,
    input  logic          data_we,
    input  logic [DW-1:0] data_in,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_in,
    input  logic [1:0]    sel_in,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] word_q,
    output logic [AW-1:0] addr_q,
    output logic [1:0]    sel_q
);
    // Capture writes only while empty; the launch sets full, take clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            word_q <= '0;
            addr_q <= '0;
            sel_q  <= '0;
        end else begin
            if (!full && data_we) word_q <= data_in;
            if (!full && addr_we) begin
                addr_q <= addr_in;
                sel_q  <= sel_in;
                if (prog_mode) full <= 1'b1;
            end
            if (take) full <= 1'b0;
        end
    end

    // R2: a data write that arrives while the buffer is full leaves the word unchanged
    a_r2_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (full && data_we) |=> $stable(word_q));
    // R2: an address write that arrives while the buffer is full leaves the address unchanged
    a_r2_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (full && addr_we) |=> $stable(addr_q));
endmodule

// File: rtl/otp_us_timer.sv
// Microsecond down-counter. 'load' presets the count, and each tick lowers it
// by one until it reaches zero. 'expired' is high while the count is zero.
// Assumes a load value of at least 1 for every timed phase.
module otp_us_timer #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Preset on load, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (tick && cnt != 0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R7: once expired, the count stays at zero until the next load
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/otp_pulse_fsm.sv
// Pulse sequencer. It takes a request from the buffer, raises program enable,
// waits the setup time, then pulses every set bit from the lowest upward, one
// array pass at a time. Consecutive pulses are separated by the gap time.
// After the last pulse it waits the hold time, drops program enable and waits
// the recovery time. Assumes all timing parameters fit in TW bits and are >= 1.
module otp_pulse_fsm
    import otp_prog_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 10,
    parameter int TW       = 7,
    parameter int SETUP_US = 10,
    parameter int PULSE_US = 12,
    parameter int GAP_US   = 2,
    parameter int HOLD_US  = 10,
    parameter int RECOV_US = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  buf_full,
    input  logic [DW-1:0]         buf_word,
    input  logic [AW-1:0]         buf_addr,
    input  logic [1:0]            buf_sel,
    input  logic                  expired,
    output logic                  take,
    output logic                  tmr_load,
    output logic [TW-1:0]         tmr_val,
    output logic                  busy,
    output logic [AW-1:0]         mac_addr,
    output logic [$clog2(DW)-1:0] mac_bit,
    output logic [1:0]            mac_arr,
    output logic                  pgm_en,
    output logic                  pulse
);
    localparam int BW = $clog2(DW);

    seq_state_e    state;
    logic [DW-1:0] word_w;
    logic [DW-1:0] mask;
    logic [AW-1:0] addr_w;
    logic [BW-1:0] bit_w;
    logic          on_red;
    logic          red_pending;
    logic [BW-1:0] low_idx;

    // Find the lowest bit of the working mask that still needs a pulse.
    always_comb begin
        low_idx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (mask[i]) low_idx = BW'(i);
        end
    end

    // Take the request, and choose when the timer reloads and with which value.
    always_comb begin
        take     = (state == SQ_IDLE) && buf_full;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            SQ_IDLE:  if (buf_full && buf_sel != ARR_RSVD) begin
                          tmr_load = 1'b1; tmr_val = TW'(SETUP_US);
                      end
            SQ_SCAN:  if (mask != '0) begin
                          tmr_load = 1'b1; tmr_val = TW'(PULSE_US);
                      end else if (!red_pending) begin
                          tmr_load = 1'b1; tmr_val = TW'(HOLD_US);
                      end
            SQ_PULSE: if (expired) begin
                          tmr_load = 1'b1;
                          tmr_val  = (mask != '0 || red_pending) ? TW'(GAP_US) : TW'(HOLD_US);
                      end
            SQ_HOLD:  if (expired) begin
                          tmr_load = 1'b1; tmr_val = TW'(RECOV_US);
                      end
            default: ;
        endcase
    end

    // Step through the phases and keep the working copy of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            word_w      <= '0;
            mask        <= '0;
            addr_w      <= '0;
            bit_w       <= '0;
            on_red      <= 1'b0;
            red_pending <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: if (buf_full && buf_sel != ARR_RSVD) begin
                    word_w      <= buf_word;
                    mask        <= buf_word;
                    addr_w      <= buf_addr;
                    on_red      <= (buf_sel == ARR_RED);
                    red_pending <= (buf_sel == ARR_BOTH);
                    state       <= SQ_SETUP;
                end
                SQ_SETUP: if (expired) state <= SQ_SCAN;
                SQ_SCAN: begin
                    if (mask != '0) begin
                        bit_w <= low_idx;
                        mask  <= mask & (mask - 1'b1);
                        state <= SQ_PULSE;
                    end else if (red_pending) begin
                        mask        <= word_w;
                        on_red      <= 1'b1;
                        red_pending <= 1'b0;
                    end else begin
                        state <= SQ_HOLD;
                    end
                end
                SQ_PULSE: if (expired) state <= (mask != '0 || red_pending) ? SQ_GAP : SQ_HOLD;
                SQ_GAP:   if (expired) state <= SQ_SCAN;
                SQ_HOLD:  if (expired) state <= SQ_RECOV;
                SQ_RECOV: if (expired) state <= SQ_IDLE;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

    assign busy     = (state != SQ_IDLE);
    assign pgm_en   = busy && (state != SQ_RECOV);
    assign pulse    = (state == SQ_PULSE);
    assign mac_addr = addr_w;
    assign mac_bit  = bit_w;
    assign mac_arr  = pgm_en ? (on_red ? 2'b10 : 2'b01) : 2'b00;

    // R7: a pulse is only ever driven inside a program-enable window
    a_r7_pulse_in_en: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> pgm_en);
    // R5: exactly one array is selected while a pulse is active
    a_r5_one_array: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> ($countones(mac_arr) == 1));
    // R6: a reserved-select request is dropped and the sequencer stays idle
    a_r6_rsvd_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && buf_full && buf_sel == ARR_RSVD) |=> (!busy && !pgm_en));
    // R9: program enable never falls straight into idle; the recovery phase comes between
    a_r9_recovery_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_en) |-> busy);
endmodule

// File: rtl/otp_prog_seq.sv
// Top of the OTP word programming sequencer: the staging buffer, the
// microsecond timer and the pulse sequencer. The status outputs are
// buffer-empty and programming-ready. Assumes us_tick is a single-cycle pulse
// in the clk domain and that power and mode sequencing are handled elsewhere.
module otp_prog_seq #(
    parameter int DW       = 32,
    parameter int AW       = 10,
    parameter int TW       = 7,
    parameter int SETUP_US = 10,
    parameter int PULSE_US = 12,
    parameter int GAP_US   = 2,
    parameter int HOLD_US  = 10,
    parameter int RECOV_US = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  us_tick,
    input  logic                  prog_mode,
    input  logic [1:0]            arr_sel_in,
    input  logic                  data_we,
    input  logic [DW-1:0]         data_in,
    input  logic                  addr_we,
    input  logic [AW-1:0]         addr_in,
    output logic                  stat_empty,
    output logic                  stat_ready,
    output logic [AW-1:0]         otp_addr,
    output logic [$clog2(DW)-1:0] otp_bit,
    output logic [1:0]            otp_arr,
    output logic                  otp_pgm_en,
    output logic                  otp_pulse
);
    logic          full, take, tmr_load, expired, busy;
    logic [DW-1:0] word_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    sel_q;
    logic [TW-1:0] tmr_val;

    otp_pbuf #(.DW(DW), .AW(AW)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
        .data_we(data_we), .data_in(data_in),
        .addr_we(addr_we), .addr_in(addr_in), .sel_in(arr_sel_in),
        .take(take), .full(full), .word_q(word_q), .addr_q(addr_q), .sel_q(sel_q)
    );

    otp_us_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    otp_pulse_fsm #(
        .DW(DW), .AW(AW), .TW(TW), .SETUP_US(SETUP_US), .PULSE_US(PULSE_US),
        .GAP_US(GAP_US), .HOLD_US(HOLD_US), .RECOV_US(RECOV_US)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .buf_full(full), .buf_word(word_q),
        .buf_addr(addr_q), .buf_sel(sel_q), .expired(expired),
        .take(take), .tmr_load(tmr_load), .tmr_val(tmr_val), .busy(busy),
        .mac_addr(otp_addr), .mac_bit(otp_bit), .mac_arr(otp_arr),
        .pgm_en(otp_pgm_en), .pulse(otp_pulse)
    );

    assign stat_empty = !full;
    assign stat_ready = !busy;

    // R10: a taken buffer is always free on the following cycle
    a_r10_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> stat_empty);
    // R1: an idle sequencer never drives program enable
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ready |-> !otp_pgm_en);
endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
    localparam int SETUP = 5, PW = 10, GAP = 1, HOLD = 5, RECOV = 5;

    logic        clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, prog_mode = 1'b0;
    logic [1:0]  arr_sel_in = '0;
    logic        data_we = 1'b0, addr_we = 1'b0;
    logic [31:0] data_in = '0;
    logic [9:0]  addr_in = '0;
    logic        stat_empty, stat_ready, otp_pgm_en, otp_pulse;
    logic [9:0]  otp_addr;
    logic [4:0]  otp_bit;
    logic [1:0]  otp_arr;

    int total = 0, bad = 0;
    bit done = 0;

    otp_prog_seq #(.SETUP_US(SETUP), .PULSE_US(PW), .GAP_US(GAP),
                   .HOLD_US(HOLD), .RECOV_US(RECOV)) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .prog_mode(prog_mode),
        .arr_sel_in(arr_sel_in), .data_we(data_we), .data_in(data_in),
        .addr_we(addr_we), .addr_in(addr_in), .stat_empty(stat_empty),
        .stat_ready(stat_ready), .otp_addr(otp_addr), .otp_bit(otp_bit),
        .otp_arr(otp_arr), .otp_pgm_en(otp_pgm_en), .otp_pulse(otp_pulse)
    );

    always #10 clk = ~clk;

    // One tick every four clocks, changed just after the rising edge
    initial begin
        int c = 0;
        forever begin
            @(posedge clk); #1;
            us_tick = (c % 4 == 3);
            c++;
        end
    end

    // Expected pulse list and monitor counters
    int exp_bit[0:127], exp_arr[0:127], exp_addr[0:127];
    int exp_n = 0, mon_pulses = 0, mon_order_err = 0, mon_width_err = 0;
    int mon_gap_ticks = 0, mon_rec_ticks = 0, mon_en_cycles = 0, cur_w = 0;
    logic prev_pulse = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (otp_pgm_en) mon_en_cycles++;
            if (otp_pgm_en && !otp_pulse && us_tick) mon_gap_ticks++;
            if (!otp_pgm_en && !stat_ready && us_tick) mon_rec_ticks++;
            if (otp_pulse && !prev_pulse) begin
                if (mon_pulses >= exp_n || int'(otp_bit) != exp_bit[mon_pulses] ||
                    int'(otp_arr) != exp_arr[mon_pulses] || int'(otp_addr) != exp_addr[mon_pulses])
                    mon_order_err++;
                mon_pulses++;
                cur_w = 0;
            end
            if (otp_pulse && us_tick) cur_w++;
            if (!otp_pulse && prev_pulse && cur_w != PW) mon_width_err++;
        end
        prev_pulse = otp_pulse;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_mon();
        exp_n = 0; mon_pulses = 0; mon_order_err = 0; mon_width_err = 0;
        mon_gap_ticks = 0; mon_rec_ticks = 0; mon_en_cycles = 0;
    endtask

    // Append the expected pulses of one request (R4, R5): array 1 normal, 2 redundancy
    task automatic add_exp(input logic [31:0] d, input logic [9:0] a, input logic [1:0] s);
        for (int pass = 0; pass < 2; pass++) begin
            int arr = (pass == 0) ? 1 : 2;
            if ((s == 2'd0) || (s == 2'd1 && pass == 0) || (s == 2'd2 && pass == 1))
                for (int b = 0; b < 32; b++)
                    if (d[b]) begin
                        exp_bit[exp_n] = b; exp_arr[exp_n] = arr; exp_addr[exp_n] = int'(a);
                        exp_n++;
                    end
        end
    endtask

    task automatic write_req(input logic [31:0] d, input logic [9:0] a, input logic [1:0] s,
                             input logic pm);
        @(posedge clk); #2;
        data_in = d; data_we = 1'b1;
        @(posedge clk); #2;
        data_we = 1'b0; addr_in = a; arr_sel_in = s; prog_mode = pm; addr_we = 1'b1;
        @(posedge clk); #2;
        addr_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (!(stat_ready && stat_empty) && n < 20000);
    endtask

    // Table: {sel, addr, data}
    localparam logic [43:0] VEC [6] = '{
        {2'd1, 10'h005, 32'h0000_0001},
        {2'd2, 10'h3FF, 32'h8000_0000},
        {2'd0, 10'h123, 32'h0000_00A5},
        {2'd1, 10'h200, 32'hFFFF_FFFF},
        {2'd0, 10'h001, 32'h0000_0000},
        {2'd2, 10'h0AA, 32'h8000_0001}
    };

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(stat_empty === 1'b1, "R1 empty", int'(stat_empty), 1);
        chk(stat_ready === 1'b1, "R1 ready", int'(stat_ready), 1);
        chk(otp_pgm_en === 1'b0 && otp_pulse === 1'b0, "R1 pgm_en/pulse", int'(otp_pgm_en), 0);

        for (int v = 0; v < 6; v++) begin
            logic [1:0]  s = VEC[v][43:42];
            logic [9:0]  a = VEC[v][41:32];
            logic [31:0] d = VEC[v][31:0];
            clear_mon();
            add_exp(d, a, s);
            write_req(d, a, s, 1'b1);
            @(negedge clk);
            chk(stat_empty === 1'b0 && stat_ready === 1'b1, "R2 empty drops on launch",
                int'({stat_empty, stat_ready}), 1);
            @(negedge clk);
            chk(stat_empty === 1'b1 && stat_ready === 1'b0, "R10 buffer freed on take",
                int'({stat_empty, stat_ready}), 2);
            wait_idle();
            chk(mon_pulses == exp_n, "R4 pulse count", mon_pulses, exp_n);
            chk(mon_order_err == 0, "R5 bit/array/address order", mon_order_err, 0);
            chk(mon_width_err == 0, "R7 pulse width", mon_width_err, 0);
            chk(mon_gap_ticks == SETUP + HOLD + GAP * ((exp_n > 0) ? exp_n - 1 : 0),
                "R8 setup+gap+hold ticks", mon_gap_ticks,
                SETUP + HOLD + GAP * ((exp_n > 0) ? exp_n - 1 : 0));
            chk(mon_rec_ticks == RECOV, "R9 recovery ticks", mon_rec_ticks, RECOV);
        end

        // R3: address write outside program mode launches nothing
        clear_mon();
        write_req(32'h0000_000F, 10'h044, 2'd1, 1'b0);
        @(negedge clk);
        chk(stat_empty === 1'b1 && stat_ready === 1'b1, "R3 no launch status",
            int'({stat_empty, stat_ready}), 3);
        repeat (40) @(negedge clk);
        chk(mon_en_cycles == 0, "R3 no program enable", mon_en_cycles, 0);

        // R6: reserved array select is a no-op
        clear_mon();
        write_req(32'h0000_0003, 10'h055, 2'd3, 1'b1);
        @(negedge clk);
        chk(stat_empty === 1'b0, "R6 empty drops", int'(stat_empty), 0);
        @(negedge clk);
        chk(stat_empty === 1'b1 && stat_ready === 1'b1, "R6 re-empties, stays ready",
            int'({stat_empty, stat_ready}), 3);
        repeat (40) @(negedge clk);
        chk(mon_en_cycles == 0 && mon_pulses == 0, "R6 no pulses", mon_pulses, 0);

        // R2: queue a second request while busy, then try to overwrite it
        clear_mon();
        add_exp(32'h0000_0003, 10'h010, 2'd1);
        add_exp(32'h0000_0010, 10'h020, 2'd2);
        write_req(32'h0000_0003, 10'h010, 2'd1, 1'b1);
        repeat (4) @(negedge clk);
        write_req(32'h0000_0010, 10'h020, 2'd2, 1'b1);
        @(negedge clk);
        chk(stat_empty === 1'b0 && stat_ready === 1'b0, "R2 queued while busy",
            int'({stat_empty, stat_ready}), 0);
        write_req(32'hFFFF_FFFF, 10'h030, 2'd1, 1'b1);
        @(negedge clk);
        chk(stat_empty === 1'b0, "R2 buffer still locked", int'(stat_empty), 0);
        begin
            int n = 0;
            while (mon_pulses < 3 && n < 20000) begin @(negedge clk); n++; end
        end
        wait_idle();
        repeat (10) @(negedge clk);
        chk(mon_pulses == 3, "R2 only queued request ran", mon_pulses, 3);
        chk(mon_order_err == 0, "R2 locked writes ignored", mon_order_err, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule